// File: doc/BRIEF.md
# Configuration Port Unlock Sequencer

This block implements the configuration front end of a legacy I/O controller. The host reaches it through two byte-wide ports on a simple strobe bus. The first is an index port at one of two addresses chosen by a strap pin. The second is a data port at the next address. After reset the block is sealed: the data port answers with all ones, and the only thing the index port does is feed a key matcher. Once the matcher sees the correct four-byte key, the index port selects a configuration register and the data port reads or writes it.

The configuration space holds several kinds of register. A 16-bit chip identifier and a version byte are read-only. A logical-device selector is read-write. A window of banked registers gives each logical device its own copy of the same offsets; one example is a port base held in a high/low byte pair. Software relocks the block by writing a fixed command value to an exit register. Bus timing is reduced to single-cycle write and read strobes, and read data is returned in a register.

Top module: `cfgport_unlock_seq`

## Requirements
- R1: After reset the block is locked, the index register holds 0x00, the logical-device number holds 0x00, and rdata holds 0xFF.
- R2: With strap_alt low the index port sits at address 0x2E; with strap_alt high it sits at 0x4E. In both cases the data port is the index port plus one. A read of any other address returns 0xFF, and a write to any other address has no effect.
- R3: The block unlocks when four consecutive index-port writes carry 0x87, 0x01, 0x55 and then a final byte. The final byte is 0x55 when strap_alt is low and 0xAA when it is high. A byte that breaks the sequence returns the matcher to its first step. If that byte is 0x87, it counts as the first step of a new attempt.
- R4: While locked, index-port and data-port reads return 0xFF. Data-port writes change nothing, and index-port writes do not change the index register.
- R5: While unlocked, an index-port write loads the index register, and an index-port read returns it. Data-port accesses go to the register that the index selects.
- R6: Register 0x20 reads the identifier high byte, 0x21 the low byte, and 0x22 the version byte. Writes to these registers are ignored.
- R7: Register 0x07 holds the logical-device number and can be read and written. Registers 0x30 to 0x30+BANK_REGS-1 are stored separately for each logical device below NUM_LDN. For any other device number they read 0x00 and ignore writes. Every other register that is not implemented reads 0x00 and ignores writes.
- R8: While unlocked, writing 0x02 to register 0x02 relocks the block. Writing any other value to register 0x02 leaves the block unlocked. Register 0x02 always reads 0x00.
- R9: A read strobe updates rdata at the next clock edge. Without a read strobe, rdata holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Strap: 0 selects port pair 0x2E/0x2F, 1 selects 0x4E/0x4F |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | ADDR_W | Host port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A write takes effect at the clock edge where its strobe is sampled. This covers the key step, the lock state, the index and the register contents. A read issued in the following cycle therefore already sees the new state. Read data appears on rdata one edge after the read strobe. The bench drives each strobe for one cycle starting at a falling edge and samples rdata at the next falling edge, which places every sample exactly one register stage after the request. Checks that something is ignored follow the offending write with a read through the same ports, so the ignored effect would show up on rdata.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam logic [7:0] KEY_B0      = 8'h87;
    localparam logic [7:0] KEY_B1      = 8'h01;
    localparam logic [7:0] KEY_B2      = 8'h55;
    localparam logic [7:0] KEY_LAST_LO = 8'h55;
    localparam logic [7:0] KEY_LAST_HI = 8'hAA;

    localparam logic [7:0] REG_EXIT    = 8'h02;
    localparam logic [7:0] EXIT_CMD    = 8'h02;
    localparam logic [7:0] REG_LDN     = 8'h07;
    localparam logic [7:0] REG_ID_HI   = 8'h20;
    localparam logic [7:0] REG_ID_LO   = 8'h21;
    localparam logic [7:0] REG_VER     = 8'h22;
    localparam logic [7:0] BANK_BASE   = 8'h30;

    typedef struct packed {
        logic       unlocked;
        logic [1:0] step;
        logic [7:0] index;
        logic [7:0] ldn;
        logic [7:0] rdata;
    } cfg_state_t;
endpackage

// File: rtl/cfgport_key_match.sv
module cfgport_key_match
    import cfgport_pkg::*;
(
    input  logic [1:0] step_i,
    input  logic [7:0] byte_i,
    input  logic       alt_i,
    output logic [1:0] step_o,
    output logic       hit_o
);
    logic [7:0] expect_b;

    always_comb begin
        unique case (step_i)
            2'd0:    expect_b = KEY_B0;
            2'd1:    expect_b = KEY_B1;
            2'd2:    expect_b = KEY_B2;
            default: expect_b = alt_i ? KEY_LAST_HI : KEY_LAST_LO;
        endcase
        hit_o = 1'b0;
        if (byte_i == expect_b) begin
            hit_o  = (step_i == 2'd3);
            step_o = (step_i == 2'd3) ? 2'd0 : step_i + 2'd1;
        end else begin
            // a stray opening byte starts a fresh attempt
            step_o = (byte_i == KEY_B0) ? 2'd1 : 2'd0;
        end
    end
endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
    import cfgport_pkg::*;
#(
    parameter int NUM_LDN   = 8,
    parameter int BANK_REGS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] ldn_i,
    input  logic [7:0] off_i,
    input  logic [7:0] wdata_i,
    output logic       hit_o,
    output logic [7:0] rdata_o
);
    localparam int          DEPTH  = NUM_LDN * BANK_REGS;
    localparam int          IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [15:0] REGS16 = 16'(BANK_REGS);
    localparam logic [8:0]  LDN9   = 9'(NUM_LDN);
    localparam logic [8:0]  REGS9  = 9'(BANK_REGS);

    logic [7:0]  mem_q [DEPTH];
    logic [8:0]  rel;
    logic [15:0] lin;
    logic [IDX_W-1:0] idx;

    always_comb begin
        rel   = {1'b0, off_i} - {1'b0, BANK_BASE};
        hit_o = !rel[8] && (rel < REGS9) && ({1'b0, ldn_i} < LDN9);
        lin   = ({8'h00, ldn_i} * REGS16) + {8'h00, rel[7:0]};
        idx   = lin[IDX_W-1:0];
        rdata_o = hit_o ? mem_q[idx] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we_i && hit_o) begin
            mem_q[idx] <= wdata_i;
        end
    end
endmodule

// File: rtl/cfgport_regmux.sv
module cfgport_regmux
    import cfgport_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'h5A39,
    parameter logic [7:0]  CHIP_VER = 8'h03
) (
    input  logic [7:0] index_i,
    input  logic [7:0] ldn_i,
    input  logic       bank_hit_i,
    input  logic [7:0] bank_data_i,
    output logic [7:0] value_o
);
    always_comb begin
        unique case (index_i)
            REG_EXIT:  value_o = 8'h00;
            REG_LDN:   value_o = ldn_i;
            REG_ID_HI: value_o = CHIP_ID[15:8];
            REG_ID_LO: value_o = CHIP_ID[7:0];
            REG_VER:   value_o = CHIP_VER;
            default:   value_o = bank_hit_i ? bank_data_i : 8'h00;
        endcase
    end
endmodule

// File: rtl/cfgport_unlock_seq.sv
module cfgport_unlock_seq
    import cfgport_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter int                 NUM_LDN   = 8,
    parameter int                 BANK_REGS = 64,
    parameter logic [15:0]        CHIP_ID   = 16'h5A39,
    parameter logic [7:0]         CHIP_VER  = 8'h03,
    parameter logic [ADDR_W-1:0]  PORT_LO   = 'h2E,
    parameter logic [ADDR_W-1:0]  PORT_HI   = 'h4E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    cfg_state_t st_d, st_q;

    logic [ADDR_W-1:0] idx_port, dat_port;
    logic              at_idx, at_dat;
    logic [1:0]        key_step;
    logic              key_hit;
    logic              bank_we, bank_hit;
    logic [7:0]        bank_data, reg_val;

    // flat views for the bound checker
    logic       unlocked_q;
    logic [7:0] index_q, ldn_q;

    assign idx_port = strap_alt ? PORT_HI : PORT_LO;
    assign dat_port = idx_port + ONE;
    assign at_idx   = (addr == idx_port);
    assign at_dat   = (addr == dat_port);

    cfgport_key_match u_key (
        .step_i (st_q.step),
        .byte_i (wdata),
        .alt_i  (strap_alt),
        .step_o (key_step),
        .hit_o  (key_hit)
    );

    assign bank_we = wr_en && at_dat && st_q.unlocked;

    cfgport_bank #(.NUM_LDN(NUM_LDN), .BANK_REGS(BANK_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bank_we),
        .ldn_i   (st_q.ldn),
        .off_i   (st_q.index),
        .wdata_i (wdata),
        .hit_o   (bank_hit),
        .rdata_o (bank_data)
    );

    cfgport_regmux #(.CHIP_ID(CHIP_ID), .CHIP_VER(CHIP_VER)) u_mux (
        .index_i     (st_q.index),
        .ldn_i       (st_q.ldn),
        .bank_hit_i  (bank_hit),
        .bank_data_i (bank_data),
        .value_o     (reg_val)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && at_idx) begin
            if (st_q.unlocked) begin
                st_d.index = wdata;
            end else begin
                st_d.step = key_step;
                if (key_hit) st_d.unlocked = 1'b1;
            end
        end
        if (wr_en && at_dat && st_q.unlocked) begin
            if (st_q.index == REG_LDN) st_d.ldn = wdata;
            if (st_q.index == REG_EXIT && wdata == EXIT_CMD) begin
                st_d.unlocked = 1'b0;
                st_d.step     = 2'd0;
            end
        end
        if (rd_en) begin
            if (at_idx && st_q.unlocked)      st_d.rdata = st_q.index;
            else if (at_dat && st_q.unlocked) st_d.rdata = reg_val;
            else                              st_d.rdata = 8'hFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{unlocked: 1'b0, step: 2'd0, index: 8'h00, ldn: 8'h00, rdata: 8'hFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata      = st_q.rdata;
    assign unlocked_q = st_q.unlocked;
    assign index_q    = st_q.index;
    assign ldn_q      = st_q.ldn;
endmodule

// File: rtl/cfgport_unlock_seq_chk.sv
module cfgport_unlock_seq_chk #(
    parameter int                ADDR_W  = 16,
    parameter logic [15:0]       CHIP_ID = 16'h5A39,
    parameter logic [ADDR_W-1:0] PORT_LO = 'h2E,
    parameter logic [ADDR_W-1:0] PORT_HI = 'h4E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strap_alt,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              unlocked,
    input logic [7:0]        index,
    input logic [7:0]        ldn
);
    logic [ADDR_W-1:0] ip, dp;
    logic [7:0]        last_b;
    assign ip     = strap_alt ? PORT_HI : PORT_LO;
    assign dp     = ip + {{(ADDR_W-1){1'b0}}, 1'b1};
    assign last_b = strap_alt ? 8'hAA : 8'h55;

    p_locked_read_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && rd_en && (addr == ip || addr == dp)) |=> (rdata == 8'hFF));

    p_locked_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && wr_en && addr == dp) |=> ($stable(ldn) && $stable(index)));

    p_unlock_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && addr == ip && wdata == last_b));

    p_exit_relocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && wr_en && addr == dp && index == 8'h02 && wdata == 8'h02) |=> !unlocked);

    p_exit_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && rd_en && addr == dp && index == 8'h02) |=> (rdata == 8'h00));

    p_id_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && rd_en && addr == dp && index == 8'h20) |=> (rdata == CHIP_ID[15:8]));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind cfgport_unlock_seq cfgport_unlock_seq_chk #(
    .ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID), .PORT_LO(PORT_LO), .PORT_HI(PORT_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .unlocked(unlocked_q), .index(index_q), .ldn(ldn_q)
);

// File: tb/test_cfgport_unlock_seq.sv
module test_cfgport_unlock_seq;
    localparam logic [15:0] ID  = 16'h5A39;
    localparam logic [7:0]  VER = 8'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  wdata = 8'h0;
    logic [7:0]  rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] ip;
    logic [7:0]  v;

    always #4 clk = ~clk;

    cfgport_unlock_seq i_cfgport_unlock_seq (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic alt);
        @(negedge clk);
        rst_n = 1'b0; strap_alt = alt; wr_en = 1'b0; rd_en = 1'b0;
        ip = alt ? 16'h004E : 16'h002E;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wreg(input logic [7:0] r, input logic [7:0] d);
        wr(ip, r); wr(ip + 16'd1, d);
    endtask

    task automatic rreg(input logic [7:0] r, output logic [7:0] d);
        wr(ip, r); rd(ip + 16'd1, d);
    endtask

    task automatic unlock();
        wr(ip, 8'h87); wr(ip, 8'h01); wr(ip, 8'h55);
        wr(ip, strap_alt ? 8'hAA : 8'h55);
    endtask

    function automatic logic [7:0] pat(input int l, input int r);
        return 8'((l * 29 + r * 7 + 3) & 255);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        do_reset(1'b0);
        check("R1 rdata after reset", rdata, 8'hFF);
        rd(ip + 16'd1, v); check("R4 locked data read", v, 8'hFF);
        rd(ip, v);         check("R4 locked index read", v, 8'hFF);
        unlock();
        rd(ip, v);         check("R1 index after reset", v, 8'h00);
        rreg(8'h07, v);    check("R1 ldn after reset", v, 8'h00);

        for (int a = 0; a < 2; a++) begin
            logic [7:0] lastb, other;
            lastb = (a == 1) ? 8'hAA : 8'h55;
            other = (a == 1) ? 8'h55 : 8'hAA;
            // R3 wrong final byte
            do_reset(a[0]);
            wr(ip, 8'h87); wr(ip, 8'h01); wr(ip, 8'h55); wr(ip, other);
            rd(ip + 16'd1, v); check("R3 wrong last byte stays locked", v, 8'hFF);
            // R3 restart on stray 0x87
            wr(ip, 8'h87); wr(ip, 8'h01); wr(ip, 8'h87); wr(ip, 8'h01);
            wr(ip, 8'h55); wr(ip, lastb);
            rreg(8'h20, v); check("R3 restart with 0x87 unlocks", v, ID[15:8]);
            // R3 broken then full key
            do_reset(a[0]);
            wr(ip, 8'h87); wr(ip, 8'h01); wr(ip, 8'h55); wr(ip, 8'h00);
            wr(ip, 8'h01); wr(ip, 8'h55); wr(ip, lastb);
            rd(ip + 16'd1, v); check("R3 partial key stays locked", v, 8'hFF);
            unlock();
            rreg(8'h21, v); check("R3 full key unlocks", v, ID[7:0]);
            // R2 key at wrong addresses
            do_reset(a[0]);
            for (int k = 0; k < 4; k++) begin
                logic [7:0] kb;
                kb = (k == 0) ? 8'h87 : (k == 1) ? 8'h01 : (k == 2) ? 8'h55 : lastb;
                wr(ip + 16'd1, kb);
            end
            rd(ip + 16'd1, v); check("R2 key on data port ignored", v, 8'hFF);
            wr(ip ^ 16'h0060, 8'h87); wr(ip ^ 16'h0060, 8'h01);
            wr(ip ^ 16'h0060, 8'h55); wr(ip ^ 16'h0060, other);
            rd(ip + 16'd1, v); check("R2 key on other strap port ignored", v, 8'hFF);
            unlock();
            rd(16'h0080, v); check("R2 foreign address read", v, 8'hFF);
            wr(16'h0080, 8'h07);
            rd(ip, v);       check("R2 foreign write no effect", v, 8'h00);
            rd(ip + 16'd1, v); check("R5 data port reads index 0", v, 8'h00);
        end

        // R6 identity, read-only
        do_reset(1'b1);
        unlock();
        rreg(8'h20, v); check("R6 id high", v, ID[15:8]);
        rreg(8'h21, v); check("R6 id low", v, ID[7:0]);
        rreg(8'h22, v); check("R6 version", v, VER);
        wreg(8'h20, 8'h00); wreg(8'h22, 8'hFF);
        rreg(8'h20, v); check("R6 id write ignored", v, ID[15:8]);
        rreg(8'h22, v); check("R6 version write ignored", v, VER);

        // R7 banked sweep
        for (int l = 0; l < 8; l++) begin
            wreg(8'h07, 8'(l));
            for (int r = 8'h30; r < 8'h70; r++) wreg(8'(r), pat(l, r));
        end
        for (int l = 0; l < 8; l++) begin
            wreg(8'h07, 8'(l));
            rreg(8'h07, v); check("R7 ldn readback", v, 8'(l));
            for (int r = 8'h30; r < 8'h70; r++) begin
                rreg(8'(r), v); check("R7 banked readback", v, pat(l, r));
            end
        end
        wreg(8'h07, 8'h09);
        wreg(8'h64, 8'hC3);
        rreg(8'h64, v); check("R7 out-of-range ldn reads zero", v, 8'h00);
        wreg(8'h07, 8'h01);
        rreg(8'h64, v); check("R7 other ldn untouched", v, pat(1, 8'h64));
        for (int r = 0; r < 256; r++) begin
            if (r == 2 || r == 7 || (r >= 8'h20 && r <= 8'h22) || (r >= 8'h30 && r < 8'h70))
                continue;
            wreg(8'(r), 8'hFF);
            rreg(8'(r), v); check("R7 unimplemented reads zero", v, 8'h00);
        end

        // R5 index port read
        wr(ip, 8'h5C);
        rd(ip, v); check("R5 index readback", v, 8'h5C);

        // R8 exit
        wreg(8'h02, 8'h03);
        rreg(8'h02, v); check("R8 other value keeps unlocked", v, 8'h00);
        rreg(8'h07, v); check("R8 still unlocked", v, 8'h01);
        wreg(8'h02, 8'h02);
        rd(ip + 16'd1, v); check("R8 exit relocks", v, 8'hFF);

        // R4 locked writes ignored
        wr(ip + 16'd1, 8'h05);
        wr(ip, 8'h07);
        unlock();
        rd(ip, v); check("R4 index unchanged while locked", v, 8'h02);
        rreg(8'h07, v); check("R4 ldn unchanged while locked", v, 8'h01);

        // R9 hold
        rreg(8'h22, v);
        repeat (3) @(negedge clk);
        wreg(8'h07, 8'h04);
        check("R9 rdata held without read", rdata, VER);

        finish_run();
    end
endmodule